// File: doc/BRIEF.md
# Conditional Sum Adder

This block is a purely combinational N-bit binary adder in the conditional-sum style. Every bit position first works out its result twice, once as if a carry of 0 arrived and once as if a carry of 1 arrived. Neighbouring groups are then joined level by level. Each join doubles the group width, and a 2:1 multiplexer picks the upper group's answer using the carry of the lower group. Because every candidate result is ready early, the incoming carry does not ripple bit by bit. It crosses one multiplexer per level, and there are log2(N) levels.

The adder takes two N-bit operands and a carry-in. It returns the N-bit sum and the carry-out in the same evaluation, with no clock and no state. N must be a power of two of at least 2; any other value is refused when the design is elaborated. Instances of widths 4, 8 and 32 are used to exercise the scaling.

Top module: `csa_adder`

## Requirements
- R1: For every operand pair and both carry-in values, the concatenation {carry_out, sum_out} equals a_in + b_in + carry_in, computed at N+1 bits.
- R2: The same RTL gives exact results at widths N = 4, 8 and 32, obtained by doubling the group size once per multiplexer level (log2(N) levels).
- R3: With b_in = 0 and carry_in = 0, sum_out equals a_in and carry_out is 0.
- R4: With a_in all ones, b_in = 0 and carry_in = 1, sum_out is all zeros and carry_out is 1: the carry crosses every level.
- R5: With a_in and b_in both all ones and carry_in = 1, sum_out is all ones and carry_out is 1.
- R6: Bit 0 of sum_out equals a_in[0] XOR b_in[0] XOR carry_in.
- R7: carry_out is 1 exactly when a_in + b_in + carry_in is at least 2^N.
- R8: When the low half of the operands produces no carry out of the low half, the upper half of sum_out equals the upper halves of a_in and b_in added with no carry (modulo 2^(N/2)).
- R9: The outputs follow input changes with no clock edge in between: the result is valid within the same time step as the inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | N | First operand |
| b_in | input | N | Second operand |
| carry_in | input | 1 | Incoming carry, weight 1 |
| sum_out | output | N | Low N bits of the sum |
| carry_out | output | 1 | Carry out of the most significant bit |

## Verification
The hardest case to reach is a carry that must pass through the resolving multiplexer at every level. That happens only when each pending upper group propagates and none of them generates, so that bit 0's carry alone decides the whole word. Random operands almost never produce this at 32 bits. Directed vectors force it: an all-ones operand against zero with the carry-in toggled, and patterns that propagate in every group except the lowest. Exhaustive sweeps at 4 and 8 bits cover every group/carry combination at those widths.

// File: rtl/csa_pkg.sv
package csa_pkg;

  // True when v is a power of two and at least 2.
  function automatic bit width_ok(input int v);
    return (v >= 2) && ((v & (v - 1)) == 0);
  endfunction

endpackage

// File: rtl/csa_mux2.sv
module csa_mux2 #(
  parameter int W = 1
) (
  input  logic         sel,
  input  logic [W-1:0] d0,
  input  logic [W-1:0] d1,
  output logic [W-1:0] y
);

  always_comb begin
    y = sel ? d1 : d0;
  end

endmodule

// File: rtl/csa_bit_cell.sv
module csa_bit_cell (
  input  logic a,
  input  logic b,
  output logic s_if0,
  output logic c_if0,
  output logic s_if1,
  output logic c_if1
);

  logic half;

  always_comb begin
    half  = a ^ b;
    s_if0 = half;
    c_if0 = a & b;
    s_if1 = ~half;
    c_if1 = a | b;
  end

endmodule

// File: rtl/csa_pair_merge.sv
// Joins two unresolved groups of width H into one group of width 2H.
// Both carry-in cases are kept for the joined group.
module csa_pair_merge #(
  parameter int H = 1
) (
  input  logic [H-1:0]   lo_s0,
  input  logic [H-1:0]   lo_s1,
  input  logic           lo_c0,
  input  logic           lo_c1,
  input  logic [H-1:0]   hi_s0,
  input  logic [H-1:0]   hi_s1,
  input  logic           hi_c0,
  input  logic           hi_c1,
  output logic [2*H-1:0] m_s0,
  output logic [2*H-1:0] m_s1,
  output logic           m_c0,
  output logic           m_c1
);

  logic [H:0] up_if0;
  logic [H:0] up_if1;

  // case 0 of the joined group: lower half saw carry 0
  csa_mux2 #(.W(H + 1)) u_sel0 (
    .sel (lo_c0),
    .d0  ({hi_c0, hi_s0}),
    .d1  ({hi_c1, hi_s1}),
    .y   (up_if0)
  );

  // case 1 of the joined group: lower half saw carry 1
  csa_mux2 #(.W(H + 1)) u_sel1 (
    .sel (lo_c1),
    .d0  ({hi_c0, hi_s0}),
    .d1  ({hi_c1, hi_s1}),
    .y   (up_if1)
  );

  always_comb begin
    m_s0 = {up_if0[H-1:0], lo_s0};
    m_c0 = up_if0[H];
    m_s1 = {up_if1[H-1:0], lo_s1};
    m_c1 = up_if1[H];
  end

endmodule

// File: rtl/csa_adder.sv
module csa_adder #(
  parameter int N = 32
) (
  input  logic [N-1:0] a_in,
  input  logic [N-1:0] b_in,
  input  logic         carry_in,
  output logic [N-1:0] sum_out,
  output logic         carry_out
);

  import csa_pkg::*;

  localparam int LEVELS = $clog2(N);

  if (!width_ok(N)) begin : g_bad_width
    $error("csa_adder: N must be a power of two and at least 2");
  end

  // per-bit dual results
  logic [N-1:0] cell_s0;
  logic [N-1:0] cell_s1;
  logic [N-1:0] cell_c0;
  logic [N-1:0] cell_c1;

  for (genvar i = 0; i < N; i++) begin : g_cell
    csa_bit_cell u_cell (
      .a     (a_in[i]),
      .b     (b_in[i]),
      .s_if0 (cell_s0[i]),
      .c_if0 (cell_c0[i]),
      .s_if1 (cell_s1[i]),
      .c_if1 (cell_c1[i])
    );
  end

  // Level L: a resolved low group of width W, plus G-1 pending groups of
  // width W that still carry both carry-in cases.
  for (genvar L = 0; L <= LEVELS; L++) begin : lv
    localparam int W  = 1 << L;
    localparam int G  = N >> L;
    localparam int NP = G - 1;

    logic [W-1:0] res_s;
    logic         res_c;

    if (L == 0) begin : g_base
      logic [1:0] bit0;
      csa_mux2 #(.W(2)) u_cin_sel (
        .sel (carry_in),
        .d0  ({cell_c0[0], cell_s0[0]}),
        .d1  ({cell_c1[0], cell_s1[0]}),
        .y   (bit0)
      );
      assign res_s = bit0[0];
      assign res_c = bit0[1];
    end else begin : g_step
      localparam int H = W / 2;
      logic [H:0] ext;
      // resolved carry of the low group picks the next group's result
      csa_mux2 #(.W(H + 1)) u_extend (
        .sel (lv[L-1].res_c),
        .d0  ({lv[L-1].g_pend.pc0[0], lv[L-1].g_pend.ps0[H-1:0]}),
        .d1  ({lv[L-1].g_pend.pc1[0], lv[L-1].g_pend.ps1[H-1:0]}),
        .y   (ext)
      );
      assign res_s = {ext[H-1:0], lv[L-1].res_s};
      assign res_c = ext[H];
    end

    if (NP > 0) begin : g_pend
      logic [NP*W-1:0] ps0;
      logic [NP*W-1:0] ps1;
      logic [NP-1:0]   pc0;
      logic [NP-1:0]   pc1;

      if (L == 0) begin : g_fill
        assign ps0 = cell_s0[N-1:1];
        assign ps1 = cell_s1[N-1:1];
        assign pc0 = cell_c0[N-1:1];
        assign pc1 = cell_c1[N-1:1];
      end else begin : g_join
        localparam int H = W / 2;
        for (genvar p = 0; p < NP; p++) begin : g_grp
          csa_pair_merge #(.H(H)) u_merge (
            .lo_s0 (lv[L-1].g_pend.ps0[(2*p+1)*H +: H]),
            .lo_s1 (lv[L-1].g_pend.ps1[(2*p+1)*H +: H]),
            .lo_c0 (lv[L-1].g_pend.pc0[2*p+1]),
            .lo_c1 (lv[L-1].g_pend.pc1[2*p+1]),
            .hi_s0 (lv[L-1].g_pend.ps0[(2*p+2)*H +: H]),
            .hi_s1 (lv[L-1].g_pend.ps1[(2*p+2)*H +: H]),
            .hi_c0 (lv[L-1].g_pend.pc0[2*p+2]),
            .hi_c1 (lv[L-1].g_pend.pc1[2*p+2]),
            .m_s0  (ps0[p*W +: W]),
            .m_s1  (ps1[p*W +: W]),
            .m_c0  (pc0[p]),
            .m_c1  (pc1[p])
          );
        end
      end
    end
  end

  assign sum_out   = lv[LEVELS].res_s;
  assign carry_out = lv[LEVELS].res_c;

endmodule

// File: rtl/csa_adder_checks.sv
module csa_adder_checks #(
  parameter int N = 32
) (
  input logic [N-1:0] a_in,
  input logic [N-1:0] b_in,
  input logic         carry_in,
  input logic [N-1:0] sum_out,
  input logic         carry_out
);

  localparam int HN = N / 2;

  logic [N:0]    ref_total;
  logic [HN:0]   low_total;
  logic [HN-1:0] high_nocarry;

  always_comb begin
    ref_total    = {1'b0, a_in} + {1'b0, b_in} + {{N{1'b0}}, carry_in};
    low_total    = {1'b0, a_in[HN-1:0]} + {1'b0, b_in[HN-1:0]} + {{HN{1'b0}}, carry_in};
    high_nocarry = a_in[N-1:HN] + b_in[N-1:HN];
  end

  always_comb begin
    p_exact_sum_r1: assert ({carry_out, sum_out} == ref_total)
      else $error("R1 sum mismatch");
    p_identity_r3: assert (!(b_in == '0 && !carry_in) || (sum_out == a_in && !carry_out))
      else $error("R3 identity broken");
    p_full_propagate_r4: assert (!(a_in == '1 && b_in == '0 && carry_in) || (sum_out == '0 && carry_out))
      else $error("R4 carry did not cross all levels");
    p_all_ones_r5: assert (!(a_in == '1 && b_in == '1 && carry_in) || (sum_out == '1 && carry_out))
      else $error("R5 all-ones case wrong");
    p_low_bit_r6: assert (sum_out[0] == (a_in[0] ^ b_in[0] ^ carry_in))
      else $error("R6 bit 0 wrong");
    p_carry_flag_r7: assert (carry_out == ref_total[N])
      else $error("R7 carry flag wrong");
    p_upper_no_carry_r8: assert (low_total[HN] || sum_out[N-1:HN] == high_nocarry)
      else $error("R8 upper half wrong");
  end

endmodule

bind csa_adder csa_adder_checks #(.N(N)) u_checks (
  .a_in      (a_in),
  .b_in      (b_in),
  .carry_in  (carry_in),
  .sum_out   (sum_out),
  .carry_out (carry_out)
);

// File: tb/csa_adder_test.sv
`timescale 1ns/1ps
module csa_adder_test;

  logic clk;
  logic rst_n;
  int   n_checks;
  int   n_fails;
  int   cycles;
  bit   done;

  logic [31:0] a32, b32, s32;
  logic        ci32, co32;
  logic [7:0]  a8, b8, s8;
  logic        ci8, co8;
  logic [3:0]  a4, b4, s4;
  logic        ci4, co4;

  csa_adder #(.N(32)) uut (
    .a_in (a32), .b_in (b32), .carry_in (ci32), .sum_out (s32), .carry_out (co32)
  );
  csa_adder #(.N(8)) uut8 (
    .a_in (a8), .b_in (b8), .carry_in (ci8), .sum_out (s8), .carry_out (co8)
  );
  csa_adder #(.N(4)) uut4 (
    .a_in (a4), .b_in (b4), .carry_in (ci4), .sum_out (s4), .carry_out (co4)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      n_fails  = n_fails + 1;
      n_checks = n_checks + 1;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<=150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive32(input logic [31:0] a, input logic [31:0] b, input logic c);
    a32 = a; b32 = b; ci32 = c;
    #1;
  endtask

  function automatic logic [32:0] ref32(input logic [31:0] a, input logic [31:0] b, input logic c);
    return {1'b0, a} + {1'b0, b} + {32'd0, c};
  endfunction

  task automatic t_reset_zero();
    // all inputs held at zero through reset
    check("R1 reset-time zero result", {co32, s32}, 64'd0);
    check("R1 reset-time zero result N=8", {co8, s8}, 64'd0);
  endtask

  task automatic t_exhaustive4();
    int bad = 0;
    for (int v = 0; v < 512; v++) begin
      a4 = v[3:0]; b4 = v[7:4]; ci4 = v[8];
      #1;
      if ({co4, s4} !== 5'(a4 + b4 + ci4)) bad++;
    end
    check("R2 exhaustive N=4 mismatches", 64'(bad), 64'd0);
  endtask

  task automatic t_exhaustive8();
    int bad = 0;
    int cbad = 0;
    for (int v = 0; v < 131072; v++) begin
      a8 = v[7:0]; b8 = v[15:8]; ci8 = v[16];
      #1;
      if ({co8, s8} !== (9'(a8) + 9'(b8) + 9'(ci8))) bad++;
      if (co8 !== ((int'(a8) + int'(b8) + int'(ci8)) >= 256)) cbad++;
    end
    check("R2 exhaustive N=8 mismatches", 64'(bad), 64'd0);
    check("R7 carry flag N=8 mismatches", 64'(cbad), 64'd0);
  endtask

  task automatic t_random32();
    int bad = 0;
    void'($urandom(12345));
    for (int k = 0; k < 3000; k++) begin
      drive32($urandom, $urandom, 1'($urandom));
      if ({co32, s32} !== ref32(a32, b32, ci32)) bad++;
    end
    check("R1 random N=32 mismatches", 64'(bad), 64'd0);
  endtask

  task automatic t_identity();
    drive32(32'hDEAD_BEEF, 32'h0, 1'b0);
    check("R3 identity sum", 64'(s32), 64'hDEAD_BEEF);
    check("R3 identity carry", 64'(co32), 64'd0);
  endtask

  task automatic t_full_propagate();
    drive32(32'hFFFF_FFFF, 32'h0, 1'b0);
    check("R4 all-ones without carry-in", {co32, s32}, 64'h0_FFFF_FFFF);
    drive32(32'hFFFF_FFFF, 32'h0, 1'b1);
    check("R4 all-ones plus carry-in", {co32, s32}, 64'h1_0000_0000);
    // propagate everywhere, generate nowhere, second operand carries the ones
    drive32(32'hAAAA_AAAA, 32'h5555_5555, 1'b1);
    check("R4 alternating propagate plus carry-in", {co32, s32}, 64'h1_0000_0000);
  endtask

  task automatic t_all_ones();
    drive32(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    check("R5 both all-ones plus carry-in", {co32, s32}, 64'h1_FFFF_FFFF);
  endtask

  task automatic t_low_bit();
    int bad = 0;
    for (int v = 0; v < 8; v++) begin
      drive32({31'h1234, v[0]}, {31'h0F0F, v[1]}, v[2]);
      if (s32[0] !== (v[0] ^ v[1] ^ v[2])) bad++;
    end
    check("R6 bit 0 across eight cases", 64'(bad), 64'd0);
  endtask

  task automatic t_carry_flag();
    drive32(32'h8000_0000, 32'h7FFF_FFFF, 1'b0);
    check("R7 just below 2^N", 64'(co32), 64'd0);
    drive32(32'h8000_0000, 32'h7FFF_FFFF, 1'b1);
    check("R7 exactly 2^N", 64'(co32), 64'd1);
  endtask

  task automatic t_upper_no_carry();
    // low halves add to 0xFFFF without carry; upper halves overflow on their own
    drive32(32'hF000_FF00, 32'h2345_00FF, 1'b0);
    check("R8 upper half without low carry", 64'(s32[31:16]), 64'h1345);
  endtask

  task automatic t_no_clock_needed();
    @(posedge clk);
    #2;
    a32 = 32'h0000_0001; b32 = 32'h0000_0001; ci32 = 1'b0;
    #1;
    check("R9 result before next edge", {co32, s32}, 64'd2);
    a32 = 32'h7FFF_FFFF;
    #1;
    check("R9 result follows second change", {co32, s32}, 64'h0_8000_0000);
  endtask

  initial begin
    n_checks = 0; n_fails = 0; cycles = 0; done = 1'b0;
    rst_n = 1'b0;
    a32 = '0; b32 = '0; ci32 = 1'b0;
    a8 = '0; b8 = '0; ci8 = 1'b0;
    a4 = '0; b4 = '0; ci4 = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset_zero();
    rst_n = 1'b1;
    @(negedge clk);
    t_identity();
    t_full_propagate();
    t_all_ones();
    t_low_bit();
    t_carry_flag();
    t_upper_no_carry();
    t_no_clock_needed();
    t_exhaustive4();
    t_exhaustive8();
    t_random32();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule